// File: doc/BRIEF.md
# Self-Normalizing Sawtooth Duty Comparator

This block turns a fractional duty command into a timing edge inside each half-period of a resonant current. A free-running ramp counter adds one every clock and is cleared by each zero-crossing pulse. The crossing detector fires twice per current cycle, so the ramp repeats at twice the resonant frequency. Its height at the moment of clearing depends on the period length. That height is taken as the amplitude of the half-period that just ended. It scales two unsigned Q0.16 fractions, the main duty and a delay-compensation duty, into count thresholds for the next half-period. The modulation output rises once the ramp reaches the main threshold and falls at the next crossing pulse. At a 100 MHz clock one count is 10 ns of duty resolution.

The block runs a four-state sequencer:
- `SDC_OFF`: disabled.
- `SDC_SYNC`: waiting for the first pulse, because the partial half-period before it is discarded.
- `SDC_LEARN`: timing one complete half-period.
- `SDC_RUN`: thresholds are valid and the output is modulated.

The transitions are:
- T_ENABLE: `SDC_OFF` to `SDC_SYNC` when the enable is high.
- T_ALIGN: `SDC_SYNC` to `SDC_LEARN` on a pulse.
- T_CAPTURE: `SDC_LEARN` to `SDC_RUN` on a pulse.
- T_DISABLE: any state to `SDC_OFF` when the enable is low.

Top module: `sawtooth_duty_cmp`

## Requirements
- R1: After reset, `ramp` and both thresholds read 0, and `thr_valid` and `mod_out` are low.
- R2: While enabled and past `SDC_OFF`, `ramp` rises by exactly one per clock. In the cycle after a cycle with `zc_pulse` high, `ramp` reads 0. The `ramp` value seen during the pulse cycle is the amplitude A of that half-period.
- R3: `ramp` saturates at 2^CNT_W-1 instead of wrapping. A saturated value is captured as the amplitude.
- R4: In `SDC_LEARN` or `SDC_RUN`, the cycle after a pulse shows `thr_main` = floor(duty_main × A / 65536). Here `duty_main` is the Q0.16 value present in the pulse cycle.
- R5: `thr_comp` is formed the same way from `duty_comp`, at the same time.
- R6: Between pulses both thresholds hold, whatever the duty inputs do.
- R7: `thr_valid` stays low through the first pulse after enabling (the alignment pulse). It goes high in the cycle after the second pulse and stays high while enabled.
- R8: With `thr_valid` high, `mod_out` goes high in the cycle after the first cycle in which `ramp` ≥ `thr_main`. It stays high until the next pulse.
- R9: `mod_out` is low in the cycle after any pulse. It does not rise in a half-period that ends before `ramp` reaches `thr_main`, including a pulse in the very cycle of reaching it.
- R10: When `enable` is low, the next cycle shows `ramp`, both thresholds, `thr_valid` and `mod_out` at 0. Pulses while disabled have no effect, and re-enabling restarts at R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable |
| zc_pulse | input | 1 | One-cycle zero-crossing pulse |
| duty_main | input | FRAC_W | Main duty, unsigned Q0.16 |
| duty_comp | input | FRAC_W | Compensation duty, unsigned Q0.16 |
| ramp | output | CNT_W | Ramp count |
| thr_main | output | CNT_W | Scaled main threshold |
| thr_comp | output | CNT_W | Scaled compensation threshold |
| thr_valid | output | 1 | Both thresholds derived from a full half-period |
| mod_out | output | 1 | Modulation signal |

## Verification
The hardest case to reach is a half-period cut short just before the output would rise. That includes a pulse landing in exactly the cycle where the ramp equals the threshold. The stimulus sets up a long half-period with a high duty, then a short one whose length is chosen from that known threshold. The length that equals the new threshold exactly comes next. Saturation is reached by running the bench with a narrow counter and holding off the pulse for longer than the counter range. A mid-period disable followed by a re-enable checks that the learning sequence starts over.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
    typedef enum logic [1:0] {
        SDC_OFF   = 2'd0,
        SDC_SYNC  = 2'd1,
        SDC_LEARN = 2'd2,
        SDC_RUN   = 2'd3
    } sdc_state_e;
endpackage

// File: rtl/sdc_ramp.sv
`timescale 1ns/1ps
// Constant-slope ramp: +1 per clock, cleared by a pulse, held at zero when idle.
module sdc_ramp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run || clr) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sdc_scale.sv
`timescale 1ns/1ps
// One registered multiply: threshold = fraction * amplitude, upper bits kept.
module sdc_scale #(
    parameter int FRAC_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr,
    input  logic [FRAC_W-1:0] frac,
    input  logic [CNT_W-1:0]  amp,
    output logic [CNT_W-1:0]  thr
);
    localparam int PROD_W = FRAC_W + CNT_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(frac) * PROD_W'(amp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr <= '0;
        end else if (clr) begin
            thr <= '0;
        end else if (load) begin
            thr <= prod[FRAC_W +: CNT_W];
        end
    end
endmodule

// File: rtl/sdc_ctrl.sv
`timescale 1ns/1ps
// Sequencer: alignment, learning half-period, running; owns valid and modulation flags.
module sdc_ctrl
    import sdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             zc_pulse,
    input  logic [CNT_W-1:0] ramp,
    input  logic [CNT_W-1:0] thr_main,
    output logic             ramp_run,
    output logic             thr_load,
    output logic             thr_clr,
    output logic             thr_valid,
    output logic             mod_out
);
    sdc_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SDC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_ENABLE, T_ALIGN, T_CAPTURE, T_DISABLE
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = SDC_OFF;                          // T_DISABLE
        end else begin
            unique case (state_q)
                SDC_OFF:   state_d = SDC_SYNC;          // T_ENABLE
                SDC_SYNC:  if (zc_pulse) state_d = SDC_LEARN;  // T_ALIGN
                SDC_LEARN: if (zc_pulse) state_d = SDC_RUN;    // T_CAPTURE
                SDC_RUN:   state_d = SDC_RUN;
                default:   state_d = SDC_OFF;
            endcase
        end
    end

    // Combinational controls to the datapath
    always_comb begin
        ramp_run = enable && (state_q != SDC_OFF);
        thr_clr  = !enable || (state_q == SDC_OFF);
        thr_load = enable && zc_pulse &&
                   ((state_q == SDC_LEARN) || (state_q == SDC_RUN));
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_valid <= 1'b0;
            mod_out   <= 1'b0;
        end else begin
            thr_valid <= enable && ((state_q == SDC_RUN) ||
                                    ((state_q == SDC_LEARN) && zc_pulse));
            if (!enable || zc_pulse) begin
                mod_out <= 1'b0;
            end else if (thr_valid && (ramp >= thr_main)) begin
                mod_out <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sawtooth_duty_cmp.sv
`timescale 1ns/1ps
module sawtooth_duty_cmp #(
    parameter int FRAC_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              zc_pulse,
    input  logic [FRAC_W-1:0] duty_main,
    input  logic [FRAC_W-1:0] duty_comp,
    output logic [CNT_W-1:0]  ramp,
    output logic [CNT_W-1:0]  thr_main,
    output logic [CNT_W-1:0]  thr_comp,
    output logic              thr_valid,
    output logic              mod_out
);
    localparam int N_THR = 2;

    logic ramp_run, thr_load, thr_clr;
    logic [FRAC_W-1:0] frac_sel [N_THR];
    logic [CNT_W-1:0]  thr_sel  [N_THR];

    assign frac_sel[0] = duty_main;
    assign frac_sel[1] = duty_comp;
    assign thr_main    = thr_sel[0];
    assign thr_comp    = thr_sel[1];

    sdc_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ramp_run),
        .clr   (zc_pulse),
        .count (ramp)
    );

    for (genvar g = 0; g < N_THR; g++) begin : g_scale
        sdc_scale #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (thr_load),
            .clr   (thr_clr),
            .frac  (frac_sel[g]),
            .amp   (ramp),
            .thr   (thr_sel[g])
        );
    end

    sdc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .zc_pulse  (zc_pulse),
        .ramp      (ramp),
        .thr_main  (thr_main),
        .ramp_run  (ramp_run),
        .thr_load  (thr_load),
        .thr_clr   (thr_clr),
        .thr_valid (thr_valid),
        .mod_out   (mod_out)
    );
endmodule

// File: rtl/sawtooth_duty_cmp_chk.sv
`timescale 1ns/1ps
module sawtooth_duty_cmp_chk #(
    parameter int FRAC_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              zc_pulse,
    input logic [FRAC_W-1:0] duty_main,
    input logic [FRAC_W-1:0] duty_comp,
    input logic [CNT_W-1:0]  ramp,
    input logic [CNT_W-1:0]  thr_main,
    input logic [CNT_W-1:0]  thr_comp,
    input logic              thr_valid,
    input logic              mod_out
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !zc_pulse && ramp != '0 && ramp != TOP) |=> (ramp == $past(ramp) + 1'b1));

    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        zc_pulse |=> (ramp == '0));

    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !zc_pulse && ramp == TOP) |=> (ramp == TOP));

    a_r6_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !zc_pulse && thr_valid) |=> ($stable(thr_main) && $stable(thr_comp)));

    a_r8_ms_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !zc_pulse && mod_out) |=> mod_out);

    a_r8_ms_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mod_out |-> thr_valid);

    a_r9_ms_low_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        zc_pulse |=> !mod_out);

    a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ramp == '0 && thr_main == '0 && thr_comp == '0 && !thr_valid && !mod_out));
endmodule

bind sawtooth_duty_cmp sawtooth_duty_cmp_chk #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .zc_pulse  (zc_pulse),
    .duty_main (duty_main),
    .duty_comp (duty_comp),
    .ramp      (ramp),
    .thr_main  (thr_main),
    .thr_comp  (thr_comp),
    .thr_valid (thr_valid),
    .mod_out   (mod_out)
);

// File: tb/sawtooth_duty_cmp_bench.sv
`timescale 1ns/1ps
module sawtooth_duty_cmp_bench;
    localparam int FRAC_W = 16;
    localparam int CNT_W  = 8;
    localparam longint MAXC = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic zc_pulse = 1'b0;
    logic [FRAC_W-1:0] duty_main = '0;
    logic [FRAC_W-1:0] duty_comp = '0;
    logic [CNT_W-1:0] ramp, thr_main, thr_comp;
    logic thr_valid, mod_out;

    always #2 clk = ~clk;

    sawtooth_duty_cmp #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_sawtooth_duty_cmp (
        .clk(clk), .rst_n(rst_n), .enable(enable), .zc_pulse(zc_pulse),
        .duty_main(duty_main), .duty_comp(duty_comp),
        .ramp(ramp), .thr_main(thr_main), .thr_comp(thr_comp),
        .thr_valid(thr_valid), .mod_out(mod_out)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit cmp_on   = 1'b0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // Behavioural reference: phase 0 idle, 1 awaiting first pulse, 2 timing, 3 running
    longint m_cnt = 0, m_tm = 0, m_tc = 0;
    int m_phase = 0;
    bit m_val = 0, m_ms = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_tm = 0; m_tc = 0; m_phase = 0; m_val = 0; m_ms = 0;
        end else begin
            longint n_cnt, n_tm, n_tc;
            int n_phase;
            bit n_val, n_ms;
            if (!enable || zc_pulse) n_ms = 0;
            else if (m_val && m_cnt >= m_tm) n_ms = 1;
            else n_ms = m_ms;
            n_val = enable && (m_phase == 3 || (m_phase == 2 && zc_pulse));
            if (!enable || m_phase == 0) begin
                n_tm = 0; n_tc = 0;
            end else if (zc_pulse && m_phase >= 2) begin
                n_tm = (longint'(duty_main) * m_cnt) / 65536;
                n_tc = (longint'(duty_comp) * m_cnt) / 65536;
            end else begin
                n_tm = m_tm; n_tc = m_tc;
            end
            if (!enable || m_phase == 0 || zc_pulse) n_cnt = 0;
            else if (m_cnt < MAXC) n_cnt = m_cnt + 1;
            else n_cnt = m_cnt;
            if (!enable) n_phase = 0;
            else if (m_phase == 0) n_phase = 1;
            else if (zc_pulse && m_phase < 3) n_phase = m_phase + 1;
            else n_phase = m_phase;
            m_cnt = n_cnt; m_tm = n_tm; m_tc = n_tc;
            m_phase = n_phase; m_val = n_val; m_ms = n_ms;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk((m_cnt == MAXC) ? "R3 ramp" : "R2 ramp", ramp, m_cnt);
            chk("R4 thr_main", thr_main, m_tm);
            chk("R5 thr_comp", thr_comp, m_tc);
            chk("R7 thr_valid", thr_valid, m_val);
            chk("R8 mod_out", mod_out, m_ms);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
            finish_run();
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic half(input int n);
        repeat (n) tick();
        zc_pulse = 1'b1;
        tick();
        zc_pulse = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 ramp", ramp, 0);
        chk("R1 thr_main", thr_main, 0);
        chk("R1 valid", thr_valid, 0);
        chk("R1 mod_out", mod_out, 0);

        // R10 pulses while disabled do nothing
        half(5);
        chk("R10 ramp idle", ramp, 0);
        chk("R10 valid idle", thr_valid, 0);

        duty_main = 16'h8000;
        duty_comp = 16'h1000;
        enable = 1'b1;
        half(7);
        chk("R7 valid after align", thr_valid, 0);
        half(100);
        chk("R4 thr 0.5*100", thr_main, 50);
        chk("R5 comp 100", thr_comp, 6);
        chk("R7 valid after capture", thr_valid, 1);

        half(100);
        duty_main = 16'h4000;
        half(80);
        duty_main = 16'hC000;
        half(120);
        half(120);

        // R6 duty change mid half-period
        repeat (30) tick();
        duty_main = 16'h2000;
        duty_comp = 16'hF000;
        tick();
        chk("R6 thr_main held", thr_main, (longint'(16'hC000) * 120) / 65536);
        chk("R6 thr_comp held", thr_comp, (longint'(16'h1000) * 120) / 65536);
        half(60);

        // R9 cut-short half-period
        duty_main = 16'hE000;
        half(200);
        chk("R4 thr 0.875*200", thr_main, 175);
        for (int i = 0; i < 60; i++) begin
            tick();
            chk("R9 short period", mod_out, 0);
        end
        zc_pulse = 1'b1;
        tick();
        zc_pulse = 1'b0;
        chk("R9 after short", mod_out, 0);
        chk("R4 thr 0.875*60", thr_main, 52);
        half(52);
        chk("R9 pulse at threshold", mod_out, 0);
        chk("R4 thr 0.875*52", thr_main, 45);

        // R3 saturation
        duty_main = 16'h8000;
        repeat (400) tick();
        chk("R3 ramp saturated", ramp, MAXC);
        zc_pulse = 1'b1;
        tick();
        zc_pulse = 1'b0;
        chk("R3 amp saturated", thr_main, 127);

        // Duty extremes
        duty_main = 16'hFFFF;
        half(100);
        chk("R4 thr max duty", thr_main, 99);
        duty_main = 16'h0001;
        half(100);
        chk("R4 thr min duty", thr_main, 0);
        half(40);

        // R10 mid-period disable then restart
        duty_main = 16'h6000;
        repeat (20) tick();
        enable = 1'b0;
        tick();
        chk("R10 ramp", ramp, 0);
        chk("R10 thr_main", thr_main, 0);
        chk("R10 thr_comp", thr_comp, 0);
        chk("R10 valid", thr_valid, 0);
        chk("R10 mod_out", mod_out, 0);
        half(10);
        chk("R10 ramp after pulse", ramp, 0);
        enable = 1'b1;
        half(15);
        chk("R10 restart no valid", thr_valid, 0);
        half(90);
        chk("R10 restart valid", thr_valid, 1);
        half(90);
        half(90);
        repeat (5) tick();
        finish_run();
    end
endmodule